// File: doc/BRIEF.md
# Chroma Upsampler and YUV-to-RGB Output Matrix

This block sits between the inset picture store and the three output converters of a picture-in-picture path. Each valid input carries one 6-bit luma sample. A new chroma pair is taken once per group of four luma samples and repeated across the group, so the chroma rate matches the luma rate. The repeated chroma stream then passes through a 3-tap 1-2-1 smoothing filter, and the luma is delayed by one sample to stay aligned with it.

The filtered samples are then converted to R, G and B by a matrix whose coefficients are sums of powers of two. In the alternative output format the matrix is skipped: luma passes straight through and both chroma components are negated. Each result is mapped onto one of three 6-bit output channels. The output format is taken from a control input on the first sample of every line, so a single line never mixes the two formats.

Top module: `pip_yuv_rgb_out`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `out_valid` and all three channel codes to 0 and sets the held output format to YUV.
- R2: Every input cycle with `in_valid` high produces exactly one output cycle with `out_valid` high, two rising clock edges later. `out_valid` is low in every other cycle.
- R3: Counting valid samples from a `line_start` sample (count 0), `u_in`/`v_in` are captured only at counts 0, 4, 8 and so on. That value is reused for the three samples that follow, and chroma inputs at other counts have no effect.
- R4: The chroma applied to a sample equals floor((p + 2c + n + 2) / 4). Here c is its repeated chroma, p is that of the valid sample in the previous cycle, and n is that of the valid sample in the next cycle. If the neighbour is missing (no valid in that cycle), or if it lies in another line (this sample, or the next one, carries `line_start`), c is used in its place.
- R5: `u_in` and `v_in` are 6-bit two's complement values (-32 to 31), and `y_in` is unsigned (0 to 63).
- R6: In RGB format, each result is computed in sixteenths: R = 16Y+12V, G = 16Y-6V-3U and B = 16Y+16U. Each sum has 8 added, is divided by 16 with rounding toward minus infinity, and is then clamped to 0..63.
- R7: In RGB format, `out_ch1` carries R, `out_ch2` carries G and `out_ch3` carries B.
- R8: In YUV format, `out_ch2` = Y, `out_ch1` = 32 + min(-V, 31) and `out_ch3` = 32 + min(-U, 31). These use the filtered chroma.
- R9: `fmt_rgb` (1 = RGB, 0 = YUV) is sampled only on a valid sample that carries `line_start`, and it governs that line. Changes on other samples are ignored. Samples that come before the first line start use YUV.
- R10: `line_start` has no effect in a cycle where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| line_start | input | 1 | Marks the first valid sample of a line |
| fmt_rgb | input | 1 | Output format request: 1 RGB, 0 YUV |
| y_in | input | 6 | Luma sample, unsigned |
| u_in | input | 6 | U chroma sample, two's complement |
| v_in | input | 6 | V chroma sample, two's complement |
| out_valid | output | 1 | Output codes are valid |
| out_ch1 | output | 6 | Channel 1 code (R or offset -V) |
| out_ch2 | output | 6 | Channel 2 code (G or Y) |
| out_ch3 | output | 6 | Channel 3 code (B or offset -U) |

## Verification
The checker watches several behaviours on every cycle:
- the two-edge valid pipeline;
- luma passing unchanged through channel 2 in YUV format;
- the RGB matrix reducing to three copies of luma when the filtered chroma is zero;
- repeated chroma staying constant inside a group of four;
- the format staying fixed between adjacent samples of one line.

Only the bench scenarios show the exact filter outputs at line edges and across line boundaries, floor rounding of negative sums, saturation at both ends, the clamp on negated -32, and the channel permutation with non-zero chroma. They also cover format requests that arrive mid-line or with a bare `line_start` pulse, which must be ignored.

// File: rtl/pip_out_pkg.sv
// Shared definitions for the inset output colour path.
// Assumes: the matrix fraction width is at least 4, so every coefficient is
// an exact sum of shifted copies of its operand.
package pip_out_pkg;

    // Output format held per line
    typedef enum logic {
        FMT_YUV = 1'b0,
        FMT_RGB = 1'b1
    } out_fmt_e;

    // Fraction bits of the colour matrix accumulator (coefficients in 1/16)
    localparam int COEF_FRAC = 4;

endpackage

// File: rtl/pip_chroma_rep.sv
// Chroma repetition and line bookkeeping stage.
// Counts valid samples from each line start and captures a new chroma pair
// at the first sample of every group of REP. It repeats that pair for the
// rest of the group. It latches the output format on the line-start sample and
// registers luma, format and line position for one sample of alignment.
// Assumes: REP >= 2; line_start only counts together with in_valid.
module pip_chroma_rep
    import pip_out_pkg::*;
#(
    parameter int W   = 6,
    parameter int REP = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    line_start,
    input  logic                    fmt_rgb,
    input  logic [W-1:0]            y_in,
    input  logic [W-1:0]            u_in,
    input  logic [W-1:0]            v_in,
    output logic [W-1:0]            rep_u,
    output logic [W-1:0]            rep_v,
    output logic                    st_valid,
    output logic                    st_first,
    output out_fmt_e                st_fmt,
    output logic [W-1:0]            st_y,
    output logic [$clog2(REP)-1:0]  st_phase
);

    localparam int PH_W = $clog2(REP);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(REP - 1);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_cur;
    logic            take;
    logic [W-1:0]    hold_u;
    logic [W-1:0]    hold_v;
    out_fmt_e        fmt_q;
    out_fmt_e        fmt_cur;

    // Position of the current sample in its chroma group, and its format
    always_comb begin
        ph_cur  = line_start ? '0 : ph_q;
        take    = (ph_cur == '0);
        rep_u   = take ? u_in : hold_u;
        rep_v   = take ? v_in : hold_v;
        fmt_cur = line_start ? out_fmt_e'(fmt_rgb) : fmt_q;
    end

    // Advance group counter, hold chroma and format on each valid sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            hold_u <= '0;
            hold_v <= '0;
            fmt_q  <= FMT_YUV;
        end else if (in_valid) begin
            ph_q   <= (ph_cur == PH_LAST) ? '0 : ph_cur + 1'b1;
            hold_u <= rep_u;
            hold_v <= rep_v;
            fmt_q  <= fmt_cur;
        end
    end

    // Alignment register: luma and per-sample attributes, one sample deep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_first <= 1'b0;
            st_fmt   <= FMT_YUV;
            st_y     <= '0;
            st_phase <= '0;
        end else begin
            st_valid <= in_valid;
            if (in_valid) begin
                st_first <= line_start;
                st_fmt   <= fmt_cur;
                st_y     <= y_in;
                st_phase <= ph_cur;
            end
        end
    end

endmodule

// File: rtl/pip_chroma_fir3.sv
// Centred 1-2-1 smoothing filter for one repeated chroma stream.
// Holds the centre sample and its predecessor. It takes the incoming sample
// as the look-ahead tap, so the filtered value of a sample is ready one cycle
// after that sample arrives. A neighbour that is absent in its cycle, or that
// belongs to another line, is replaced by the centre sample.
// Assumes: two's complement chroma; result = floor((p + 2c + n + 2) / 4).
module pip_chroma_fir3 #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         nxt_valid,
    input  logic         nxt_first,
    input  logic [W-1:0] nxt_c,
    output logic [W-1:0] ctr_c,
    output logic [W-1:0] filt_c
);

    localparam int SW = W + 2;

    logic         ctr_vld;
    logic         ctr_first;
    logic [W-1:0] prv_c;
    logic         prv_vld;
    logic         prev_ok;
    logic         next_ok;
    logic [W-1:0] tap_p;
    logic [W-1:0] tap_n;
    logic signed [SW-1:0] sum;

    // Shift the tap line by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_c     <= '0;
            ctr_vld   <= 1'b0;
            ctr_first <= 1'b0;
            prv_c     <= '0;
            prv_vld   <= 1'b0;
        end else begin
            ctr_vld <= nxt_valid;
            prv_vld <= ctr_vld;
            prv_c   <= ctr_c;
            if (nxt_valid) begin
                ctr_c     <= nxt_c;
                ctr_first <= nxt_first;
            end
        end
    end

    // Pick neighbours with edge replication, then weight and round
    always_comb begin
        prev_ok = prv_vld && !ctr_first;
        next_ok = nxt_valid && !nxt_first;
        tap_p   = prev_ok ? prv_c : ctr_c;
        tap_n   = next_ok ? nxt_c : ctr_c;
        sum     = SW'($signed(tap_p))
                + (SW'($signed(ctr_c)) <<< 1)
                + SW'($signed(tap_n))
                + SW'(2);
        filt_c  = W'(sum >>> 2);
    end

endmodule

// File: rtl/pip_color_matrix.sv
// Colour conversion and channel mapping.
// In RGB format: shift-and-add matrix in units of 2^-COEF_FRAC, rounded to
// nearest and saturated to the code range. In YUV format: luma unchanged,
// chroma negated, clamped and moved to offset binary.
// Channels: RGB -> (R, G, B), YUV -> (-V, Y, -U).
// Assumes: COEF_FRAC >= 4; purely combinational.
module pip_color_matrix
    import pip_out_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0] y,
    input  logic [W-1:0] u,
    input  logic [W-1:0] v,
    input  out_fmt_e     fmt,
    output logic [W-1:0] ch1,
    output logic [W-1:0] ch2,
    output logic [W-1:0] ch3
);

    localparam int FR = COEF_FRAC;
    localparam int AW = W + FR + 3;
    localparam logic signed [AW-1:0] RND     = AW'(1 << (FR - 1));
    localparam logic signed [AW-1:0] MAX_S   = AW'((1 << W) - 1);
    localparam logic signed [AW-1:0] HALF_S  = AW'(1 << (W - 1));
    localparam logic signed [AW-1:0] HALF_M1 = AW'((1 << (W - 1)) - 1);

    logic signed [AW-1:0] ys;
    logic signed [AW-1:0] us;
    logic signed [AW-1:0] vs;
    logic signed [AW-1:0] acc_r;
    logic signed [AW-1:0] acc_g;
    logic signed [AW-1:0] acc_b;

    // Drop the fraction and clamp to 0 .. 2^W-1
    function automatic logic [W-1:0] clip_code(input logic signed [AW-1:0] a);
        logic signed [AW-1:0] q;
        q = a >>> FR;
        if (q[AW-1])
            clip_code = '0;
        else if (q > MAX_S)
            clip_code = W'(MAX_S);
        else
            clip_code = W'(q);
    endfunction

    // Negate, clamp to the positive limit, add the mid-scale offset
    function automatic logic [W-1:0] neg_offset(input logic signed [AW-1:0] s);
        logic signed [AW-1:0] n;
        n = -s;
        if (n > HALF_M1)
            n = HALF_M1;
        neg_offset = W'(n + HALF_S);
    endfunction

    // Operand extension and the three matrix sums
    always_comb begin
        ys    = {{(AW - W){1'b0}}, y} <<< FR;
        us    = {{(AW - W){u[W-1]}}, u};
        vs    = {{(AW - W){v[W-1]}}, v};
        acc_r = ys + (vs <<< (FR - 1)) + (vs <<< (FR - 2)) + RND;
        acc_g = ys - (vs <<< (FR - 2)) - (vs <<< (FR - 3))
                   - (us <<< (FR - 3)) - (us <<< (FR - 4)) + RND;
        acc_b = ys + (us <<< FR) + RND;
    end

    // Format selection and channel mapping
    always_comb begin
        if (fmt == FMT_RGB) begin
            ch1 = clip_code(acc_r);
            ch2 = clip_code(acc_g);
            ch3 = clip_code(acc_b);
        end else begin
            ch1 = neg_offset(vs);
            ch2 = y;
            ch3 = neg_offset(us);
        end
    end

endmodule

// File: rtl/pip_yuv_rgb_out.sv
// Inset output colour path, top level.
// Chroma repetition, one centred smoothing filter per chroma component,
// colour matrix or bypass, and a registered output stage. A sample presented
// with in_valid appears on the channel outputs two clock edges later.
// Assumes: samples of one line arrive on consecutive cycles when the filter
// is to see both neighbours; a gap acts as a line edge.
module pip_yuv_rgb_out
    import pip_out_pkg::*;
#(
    parameter int PIX_W      = 6,
    parameter int CHROMA_REP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             line_start,
    input  logic             fmt_rgb,
    input  logic [PIX_W-1:0] y_in,
    input  logic [PIX_W-1:0] u_in,
    input  logic [PIX_W-1:0] v_in,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_ch1,
    output logic [PIX_W-1:0] out_ch2,
    output logic [PIX_W-1:0] out_ch3
);

    localparam int NCH  = 2;
    localparam int PH_W = $clog2(CHROMA_REP);

    logic [PIX_W-1:0] rep_c  [NCH];
    logic [PIX_W-1:0] ctr_c  [NCH];
    logic [PIX_W-1:0] filt_c [NCH];
    logic             st_valid;
    logic             st_first;
    out_fmt_e         st_fmt;
    logic [PIX_W-1:0] st_y;
    logic [PH_W-1:0]  st_phase;
    logic [PIX_W-1:0] mx_ch1;
    logic [PIX_W-1:0] mx_ch2;
    logic [PIX_W-1:0] mx_ch3;

    pip_chroma_rep #(
        .W   (PIX_W),
        .REP (CHROMA_REP)
    ) u_rep (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .line_start (line_start),
        .fmt_rgb    (fmt_rgb),
        .y_in       (y_in),
        .u_in       (u_in),
        .v_in       (v_in),
        .rep_u      (rep_c[0]),
        .rep_v      (rep_c[1]),
        .st_valid   (st_valid),
        .st_first   (st_first),
        .st_fmt     (st_fmt),
        .st_y       (st_y),
        .st_phase   (st_phase)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_fir
        pip_chroma_fir3 #(
            .W (PIX_W)
        ) u_fir (
            .clk       (clk),
            .rst_n     (rst_n),
            .nxt_valid (in_valid),
            .nxt_first (line_start),
            .nxt_c     (rep_c[c]),
            .ctr_c     (ctr_c[c]),
            .filt_c    (filt_c[c])
        );
    end

    pip_color_matrix #(
        .W (PIX_W)
    ) u_mtx (
        .y   (st_y),
        .u   (filt_c[0]),
        .v   (filt_c[1]),
        .fmt (st_fmt),
        .ch1 (mx_ch1),
        .ch2 (mx_ch2),
        .ch3 (mx_ch3)
    );

    // Output register: codes update only with a valid sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ch1   <= '0;
            out_ch2   <= '0;
            out_ch3   <= '0;
        end else begin
            out_valid <= st_valid;
            if (st_valid) begin
                out_ch1 <= mx_ch1;
                out_ch2 <= mx_ch2;
                out_ch3 <= mx_ch3;
            end
        end
    end

endmodule

// File: rtl/pip_out_checker.sv
// Cycle-by-cycle properties of the output colour path, bound to the top.
// Assumes: reset is held for at least two clock edges at start-up.
module pip_out_checker #(
    parameter int W    = 6,
    parameter int PH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            st_valid,
    input logic            st_first,
    input logic            st_rgb,
    input logic [W-1:0]    st_y,
    input logic [PH_W-1:0] st_phase,
    input logic [W-1:0]    ctr_u,
    input logic [W-1:0]    ctr_v,
    input logic [W-1:0]    filt_u,
    input logic [W-1:0]    filt_v,
    input logic            out_valid,
    input logic [W-1:0]    out_ch1,
    input logic [W-1:0]    out_ch2,
    input logic [W-1:0]    out_ch3
);

    // R2: an aligned sample always reaches the output one edge later
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> out_valid);

    // R2: no output strobe without an aligned sample
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> !out_valid);

    // R8: luma passes unchanged to channel 2 in YUV format
    assert_bypass_luma_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_rgb) |=> (out_ch2 == $past(st_y)));

    // R6: with zero filtered chroma the matrix gives luma on all channels
    assert_neutral_grey_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_rgb && filt_u == '0 && filt_v == '0) |=>
        (out_ch1 == $past(st_y) && out_ch2 == $past(st_y) && out_ch3 == $past(st_y)));

    // R3: chroma is held inside a repetition group
    assert_chroma_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && $past(st_valid) && st_phase != '0) |->
        (ctr_u == $past(ctr_u) && ctr_v == $past(ctr_v)));

    // R9: format does not change between adjacent samples of one line
    assert_fmt_per_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && $past(st_valid) && !st_first) |-> (st_rgb == $past(st_rgb)));

endmodule

bind pip_yuv_rgb_out pip_out_checker #(
    .W    (PIX_W),
    .PH_W ($clog2(CHROMA_REP))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_first  (st_first),
    .st_rgb    (st_fmt),
    .st_y      (st_y),
    .st_phase  (st_phase),
    .ctr_u     (ctr_c[0]),
    .ctr_v     (ctr_c[1]),
    .filt_u    (filt_c[0]),
    .filt_v    (filt_c[1]),
    .out_valid (out_valid),
    .out_ch1   (out_ch1),
    .out_ch2   (out_ch2),
    .out_ch3   (out_ch3)
);

// File: tb/tb_pip_yuv_rgb_out.sv
`timescale 1ns/1ps
module tb_pip_yuv_rgb_out;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       line_start = 1'b0;
    logic       fmt_rgb = 1'b0;
    logic [5:0] y_in = '0;
    logic [5:0] u_in = '0;
    logic [5:0] v_in = '0;
    logic       out_valid;
    logic [5:0] out_ch1;
    logic [5:0] out_ch2;
    logic [5:0] out_ch3;

    int total = 0;
    int bad   = 0;
    logic [17:0] cap [64];
    int cap_n = 0;

    // Isolated single-sample lines: fmt, y, u, v, expected ch1, ch2, ch3
    localparam int NVEC = 10;
    localparam int VEC [NVEC][7] = '{
        '{1, 32,   0,   0, 32, 32, 32},
        '{1, 20,   8,   8, 26, 16, 28},
        '{1, 60,  10,  10, 63, 54, 63},
        '{1,  2, -20, -20,  0, 13,  0},
        '{1, 40, -32,  31, 63, 34,  8},
        '{1,  0,   0,   0,  0,  0,  0},
        '{1, 63,   0,   0, 63, 63, 63},
        '{0, 17,   5,  -6, 38, 17, 27},
        '{0, 63, -32,  31,  1, 63, 63},
        '{0,  0,   0, -32, 63,  0, 32}
    };

    pip_yuv_rgb_out dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .line_start (line_start),
        .fmt_rgb    (fmt_rgb),
        .y_in       (y_in),
        .u_in       (u_in),
        .v_in       (v_in),
        .out_valid  (out_valid),
        .out_ch1    (out_ch1),
        .out_ch2    (out_ch2),
        .out_ch3    (out_ch3)
    );

    always #5 clk = ~clk;

    // Record every valid output away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 64) begin
            cap[cap_n] = {out_ch1, out_ch2, out_ch3};
            cap_n = cap_n + 1;
        end
    end

    task automatic put(input bit vld, input bit ls, input bit fmt,
                       input int y, input int u, input int v);
        @(negedge clk);
        in_valid   = vld;
        line_start = ls;
        fmt_rgb    = fmt;
        y_in       = 6'(y);
        u_in       = 6'(u);
        v_in       = 6'(v);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(0, 0, 0, 0, 0, 0);
    endtask

    task automatic chk(input string req, input int idx, input int e1, input int e2, input int e3);
        logic [17:0] exp_w;
        exp_w = {6'(e1), 6'(e2), 6'(e3)};
        total++;
        if (idx >= cap_n) begin
            bad++;
            $display("FAIL %s sample %0d: actual=missing expected=%0d,%0d,%0d", req, idx, e1, e2, e3);
        end else if (cap[idx] !== exp_w) begin
            bad++;
            $display("FAIL %s sample %0d: actual=%0d,%0d,%0d expected=%0d,%0d,%0d", req, idx,
                     cap[idx][17:12], cap[idx][11:6], cap[idx][5:0], e1, e2, e3);
        end
    endtask

    task automatic chk_count(input string req, input int exp_n);
        total++;
        if (cap_n != exp_n) begin
            bad++;
            $display("FAIL %s output count: actual=%0d expected=%0d", req, cap_n, exp_n);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R2: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 out_valid: actual=%0b expected=0", out_valid);
        end
        total++;
        if ({out_ch1, out_ch2, out_ch3} !== 18'd0) begin
            bad++;
            $display("FAIL R1 codes: actual=%0d,%0d,%0d expected=0,0,0", out_ch1, out_ch2, out_ch3);
        end

        // R9: before any line start the format is YUV, even with fmt_rgb high
        cap_n = 0;
        put(1, 0, 1, 10, 0, 0);
        idle(4);
        chk("R9 reset format", 0, 32, 10, 32);

        // Table walk: R6/R7 in RGB rows, R8 in YUV rows, R5 signed chroma
        cap_n = 0;
        for (int k = 0; k < NVEC; k++) begin
            put(1, 1, VEC[k][0] != 0, VEC[k][1], VEC[k][2], VEC[k][3]);
            idle(2);
        end
        idle(3);
        for (int k = 0; k < NVEC; k++)
            chk(VEC[k][0] != 0 ? "R6/R7 matrix" : "R8 bypass", k, VEC[k][4], VEC[k][5], VEC[k][6]);
        chk_count("R2", NVEC);

        // R3/R4: chroma captured at group starts only, then smoothed
        cap_n = 0;
        put(1, 1, 0, 1,  4,   4);
        put(1, 0, 0, 2, 20, -20);
        put(1, 0, 0, 3, 20, -20);
        put(1, 0, 0, 4, 20, -20);
        put(1, 0, 0, 5,  8,   8);
        idle(4);
        chk("R3 repeat", 0, 28, 1, 28);
        chk("R3 repeat", 1, 28, 2, 28);
        chk("R3 repeat", 2, 28, 3, 28);
        chk("R4 smooth", 3, 27, 4, 27);
        chk("R4 edge",   4, 25, 5, 25);
        chk_count("R2", 5);

        // R5/R4: negative chroma with floor rounding
        cap_n = 0;
        put(1, 1, 0, 9, -3, -3);
        put(1, 0, 0, 9,  9,  9);
        put(1, 0, 0, 9,  9,  9);
        put(1, 0, 0, 9,  9,  9);
        put(1, 0, 0, 9,  0,  0);
        idle(4);
        chk("R5 signed", 0, 35, 9, 35);
        chk("R5 signed", 2, 35, 9, 35);
        chk("R4 floor",  3, 34, 9, 34);
        chk("R4 floor",  4, 33, 9, 33);

        // R4: adjacent lines must not share neighbours
        cap_n = 0;
        put(1, 1, 0, 5, -16, -16);
        put(1, 1, 0, 6,  16,  16);
        idle(4);
        chk("R4 line boundary", 0, 48, 5, 48);
        chk("R4 line boundary", 1, 16, 6, 16);

        // R9: format requests mid-line are ignored
        cap_n = 0;
        put(1, 1, 0, 10, 0, 0);
        put(1, 0, 0, 10, 0, 0);
        put(1, 0, 1, 10, 0, 0);
        put(1, 0, 1, 10, 0, 0);
        idle(2);
        put(1, 1, 1, 10, 0, 0);
        put(1, 0, 0, 11, 0, 0);
        idle(2);
        // R10: a bare line_start pulse must not reload the format
        put(0, 1, 0, 0, 0, 0);
        put(1, 0, 0, 12, 0, 0);
        idle(4);
        chk("R9 mid-line", 2, 32, 10, 32);
        chk("R9 mid-line", 3, 32, 10, 32);
        chk("R9 new line", 4, 10, 10, 10);
        chk("R9 held",     5, 11, 11, 11);
        chk("R10 ignored", 6, 12, 12, 12);
        chk_count("R2", 7);

        // R2: idle input keeps out_valid low
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R2 idle: actual=%0b expected=0", out_valid);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule